// File: doc/BRIEF.md
# Posted Write Bus Bridge Controller

This block controls how writes from a local processor bus are carried onto a shared system bus. Each processor write is latched into a single-entry buffer. The bridge then asks an arbiter for the system bus, runs the write cycle once it owns the bus, and releases the bus when no further write is waiting.

Two configuration bits decide when the processor receives its acknowledge. With posting off, which is the state after reset, the acknowledge or bus error follows the real system-bus response. With posting on, the processor is acknowledged early and the bridge finishes the cycle by itself. A slave-enable bit then decides whether that early acknowledge may come before bus ownership or must wait for it.

A bus error on a posted write never reaches the processor's bus-error line. It sets a sticky flag, and that flag drives an interrupt only when its mask bit allows it. The interrupt can therefore arrive long after the write it reports. Software clears the flag by writing 1 to it.

Top module: `pw_bridge`

## Requirements
- R1: After reset, the registers at addresses 0, 1 and 2 all read 0. The outputs cpu_ack, cpu_berr, sb_req, sb_cyc and irq are low, and writes are unposted.
- R2: With posting on (address 0 bit 0 = 1) and slave-enable off (address 0 bit 1 = 0), an accepted write raises cpu_ack for one cycle, one cycle after cpu_req is first sampled. This happens even while sb_gnt is low.
- R3: With posting on and slave-enable on, cpu_ack stays low until the bridge owns the bus. It then pulses one cycle after the first owned cycle.
- R4: A buffered write is driven with sb_cyc high and the buffered address and data on sb_addr/sb_wdata. This starts on the second cycle after the grant is sampled and lasts until sb_dack or sb_berr is sampled.
- R5: The buffer holds one write. A further write that arrives while the buffer is full gets no cpu_ack until the buffered cycle has completed.
- R6: If another write is waiting when a cycle completes, sb_req stays high. Otherwise sb_req drops one cycle after the completing cycle.
- R7: With posting off, cpu_ack pulses for one cycle in the cycle after sb_dack is sampled. A sampled sb_berr gives a one-cycle cpu_berr pulse instead. Neither signal rises earlier.
- R8: A sb_berr on a posted write never asserts cpu_berr. It sets the error flag, which reads as address 2 bit 0.
- R9: irq is the error flag ANDed with the mask bit (address 1 bit 0). Writing 1 to address 2 bit 0 clears the flag. Writing 0 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 2 | Register write data |
| cfg_rdata | output | 2 | Register read data (combinational) |
| irq | output | 1 | Posted-write error interrupt |
| cpu_req | input | 1 | Processor write request, held until acknowledged |
| cpu_addr | input | AW | Processor write address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ack | output | 1 | Write acknowledge pulse |
| cpu_berr | output | 1 | Bus error pulse (unposted writes only) |
| sb_req | output | 1 | Bus request / ownership hold to arbiter |
| sb_gnt | input | 1 | Bus grant from arbiter |
| sb_cyc | output | 1 | System-bus write cycle strobe |
| sb_addr | output | AW | System-bus address |
| sb_wdata | output | DW | System-bus write data |
| sb_dack | input | 1 | System-bus data acknowledge |
| sb_berr | input | 1 | System-bus error |

## Verification
Every processor-side result comes from a register, so it is due one clock after its cause is sampled. A posted early acknowledge appears one cycle after cpu_req is accepted. An unposted acknowledge or error appears one cycle after sb_dack or sb_berr. The error flag and the interrupt change one cycle after the failing cycle or the register write. On the bus side, sb_req rises one cycle after a request, sb_cyc rises two cycles after the grant is sampled, and release comes one cycle after the final completion. The bench drives inputs on falling edges and samples exactly at these falling edges. It also samples the cycles in between, so an early or doubled pulse is caught.

// File: rtl/pw_bridge_pkg.sv
package pw_bridge_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_ARB  = 2'd1,
    BUS_OWN  = 2'd2,
    BUS_XFER = 2'd3
  } bus_st_e;

  localparam int CFG_W = 2;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_MASK = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam int CTRL_POST_BIT = 0;
  localparam int CTRL_SLV_BIT  = 1;
  localparam int MASK_PERR_BIT = 0;
  localparam int STAT_PERR_BIT = 0;
endpackage

// File: rtl/pw_cfg_regs.sv
module pw_cfg_regs
  import pw_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             err_set,
  output logic [CFG_W-1:0] rdata,
  output logic             post_en,
  output logic             slv_en,
  output logic             irq
);
  logic post_q, post_d;
  logic slv_q, slv_d;
  logic ie_q, ie_d;
  logic flag_q, flag_d;
  logic wr_ctrl, wr_mask, wr_stat;

  assign wr_ctrl = we && (addr == REG_CTRL);
  assign wr_mask = we && (addr == REG_MASK);
  assign wr_stat = we && (addr == REG_STAT);

  always_comb begin
    post_d = post_q;
    slv_d  = slv_q;
    ie_d   = ie_q;
    flag_d = flag_q;
    if (wr_ctrl) begin
      post_d = wdata[CTRL_POST_BIT];
      slv_d  = wdata[CTRL_SLV_BIT];
    end
    if (wr_mask) ie_d = wdata[MASK_PERR_BIT];
    if (wr_stat && wdata[STAT_PERR_BIT]) flag_d = 1'b0;
    if (err_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q <= 1'b0;
      slv_q  <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      post_q <= post_d;
      slv_q  <= slv_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_CTRL: begin
        rdata[CTRL_POST_BIT] = post_q;
        rdata[CTRL_SLV_BIT]  = slv_q;
      end
      REG_MASK: rdata[MASK_PERR_BIT] = ie_q;
      REG_STAT: rdata[STAT_PERR_BIT] = flag_q;
      default:  rdata = '0;
    endcase
  end

  assign post_en = post_q;
  assign slv_en  = slv_q;
  assign irq     = flag_q && ie_q;

  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> flag_q); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !wdata[MASK_PERR_BIT]) |=> !irq); // R9
endmodule

// File: rtl/pw_post_buf.sv
module pw_post_buf #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          post_en,
  input  logic          slv_en,
  input  logic          owned,
  input  logic          done,
  input  logic          done_err,
  output logic          cpu_ack,
  output logic          cpu_berr,
  output logic          vld,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data,
  output logic          need_bus,
  output logic          err_set
);
  logic          vld_q, vld_d;
  logic          posted_q, posted_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          ack_q, ack_d;
  logic          berr_q, berr_d;
  logic          hs_q;
  logic          accept;

  assign hs_q   = ack_q || berr_q;
  assign accept = cpu_req && !hs_q && !vld_q && (!post_en || !slv_en || owned);

  always_comb begin
    vld_d    = vld_q;
    posted_d = posted_q;
    addr_d   = addr_q;
    data_d   = data_q;
    if (accept) begin
      vld_d    = 1'b1;
      posted_d = post_en;
      addr_d   = cpu_addr;
      data_d   = cpu_wdata;
    end else if (done) begin
      vld_d = 1'b0;
    end
    ack_d  = (accept && post_en) || (done && !posted_q && !done_err);
    berr_d = done && !posted_q && done_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      posted_q <= 1'b0;
      ack_q    <= 1'b0;
      berr_q   <= 1'b0;
    end else begin
      vld_q    <= vld_d;
      posted_q <= posted_d;
      ack_q    <= ack_d;
      berr_q   <= berr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign cpu_ack  = ack_q;
  assign cpu_berr = berr_q;
  assign vld      = vld_q;
  assign buf_addr = addr_q;
  assign buf_data = data_q;
  assign need_bus = vld_q || (cpu_req && !hs_q);
  assign err_set  = done && posted_q && done_err;

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !done) |=> (vld_q && $stable(addr_q) && $stable(data_q))); // R5
  AST_SLV_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vld_q) && $past(post_en) && $past(slv_en)) |-> $past(owned)); // R3
  AST_ACK_BERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_q && berr_q)); // R7
endmodule

// File: rtl/pw_bus_ctl.sv
module pw_bus_ctl
  import pw_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic need_bus,
  input  logic buf_vld,
  input  logic sb_gnt,
  input  logic sb_dack,
  input  logic sb_berr,
  output logic sb_req,
  output logic sb_cyc,
  output logic owned,
  output logic done,
  output logic done_err
);
  bus_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BUS_IDLE: if (need_bus) st_d = BUS_ARB;
      BUS_ARB:  if (sb_gnt) st_d = BUS_OWN;
      BUS_OWN: begin
        if (buf_vld)        st_d = BUS_XFER;
        else if (!need_bus) st_d = BUS_IDLE;
      end
      BUS_XFER: if (sb_dack || sb_berr) st_d = BUS_OWN;
      default:  st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BUS_IDLE;
    else        st_q <= st_d;
  end

  assign sb_req   = (st_q != BUS_IDLE);
  assign sb_cyc   = (st_q == BUS_XFER);
  assign owned    = (st_q == BUS_OWN) || (st_q == BUS_XFER);
  assign done     = sb_cyc && (sb_dack || sb_berr);
  assign done_err = sb_berr;

  AST_CYC_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    sb_cyc |-> buf_vld); // R4
  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb_req) |-> !buf_vld); // R6
endmodule

// File: rtl/pw_bridge.sv
module pw_bridge
  import pw_bridge_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             irq,
  input  logic             cpu_req,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ack,
  output logic             cpu_berr,
  output logic             sb_req,
  input  logic             sb_gnt,
  output logic             sb_cyc,
  output logic [AW-1:0]    sb_addr,
  output logic [DW-1:0]    sb_wdata,
  input  logic             sb_dack,
  input  logic             sb_berr
);
  logic [1:0] rs_q;
  logic       rst_sn;
  logic       post_en, slv_en, owned, done, done_err;
  logic       buf_vld, need_bus, err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  pw_cfg_regs i_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .err_set (err_set),
    .rdata   (cfg_rdata),
    .post_en (post_en),
    .slv_en  (slv_en),
    .irq     (irq)
  );

  pw_post_buf #(.AW(AW), .DW(DW)) i_buf (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .post_en   (post_en),
    .slv_en    (slv_en),
    .owned     (owned),
    .done      (done),
    .done_err  (done_err),
    .cpu_ack   (cpu_ack),
    .cpu_berr  (cpu_berr),
    .vld       (buf_vld),
    .buf_addr  (sb_addr),
    .buf_data  (sb_wdata),
    .need_bus  (need_bus),
    .err_set   (err_set)
  );

  pw_bus_ctl i_bus (
    .clk      (clk),
    .rst_n    (rst_sn),
    .need_bus (need_bus),
    .buf_vld  (buf_vld),
    .sb_gnt   (sb_gnt),
    .sb_dack  (sb_dack),
    .sb_berr  (sb_berr),
    .sb_req   (sb_req),
    .sb_cyc   (sb_cyc),
    .owned    (owned),
    .done     (done),
    .done_err (done_err)
  );

  AST_POSTED_NO_BERR: assert property (@(posedge clk) disable iff (!rst_sn)
    err_set |=> !cpu_berr); // R8
endmodule

// File: tb/test_pw_bridge.sv
module test_pw_bridge;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [1:0]    cfg_wdata;
  logic [1:0]    cfg_rdata;
  logic          irq;
  logic          cpu_req;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ack, cpu_berr;
  logic          sb_req, sb_gnt, sb_cyc;
  logic [AW-1:0] sb_addr;
  logic [DW-1:0] sb_wdata;
  logic          sb_dack, sb_berr;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  pw_bridge #(.AW(AW), .DW(DW)) i_pw_bridge (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq(irq),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_berr(cpu_berr),
    .sb_req(sb_req), .sb_gnt(sb_gnt), .sb_cyc(sb_cyc),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata),
    .sb_dack(sb_dack), .sb_berr(sb_berr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg_wr(logic [1:0] a, logic [1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic cfg_rd(logic [1:0] a, output logic [1:0] v);
    cfg_addr = a;
    #1;
    v = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [1:0] v;
    chk("R1 ack", cpu_ack, 0);
    chk("R1 berr", cpu_berr, 0);
    chk("R1 sb_req", sb_req, 0);
    chk("R1 sb_cyc", sb_cyc, 0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 3; a++) begin
      cfg_rd(a[1:0], v);
      chk("R1 reg", v, 0);
    end
  endtask

  // unposted write; err selects sb_berr response
  task automatic t_unposted(bit err);
    logic [1:0] v;
    cpu_req = 1; cpu_addr = 32'h1000_0040; cpu_wdata = 32'hCAFE_0001;
    step();
    chk("R7 no early ack", cpu_ack, 0);
    chk("R6 req raised", sb_req, 1);
    sb_gnt = 1;
    step();
    chk("R4 no cyc yet", sb_cyc, 0);
    step();
    chk("R4 cyc", sb_cyc, 1);
    chk("R4 addr", sb_addr, 32'h1000_0040);
    chk("R4 data", sb_wdata, 32'hCAFE_0001);
    chk("R7 still waiting", cpu_ack, 0);
    step();
    chk("R7 held till dack", cpu_ack | cpu_berr, 0);
    if (err) sb_berr = 1; else sb_dack = 1;
    step();
    sb_berr = 0; sb_dack = 0;
    chk("R7 ack", cpu_ack, !err);
    chk("R7 berr", cpu_berr, err);
    cpu_req = 0;
    step();
    chk("R7 pulse one cycle", cpu_ack | cpu_berr, 0);
    chk("R6 release", sb_req, 0);
    sb_gnt = 0;
    cfg_rd(2'd2, v);
    chk("R7 no flag on unposted", v, 0);
  endtask

  task automatic t_posted_early();
    cfg_wr(2'd0, 2'b01);
    cpu_req = 1; cpu_addr = 32'h2000_0010; cpu_wdata = 32'h1234_5678;
    step();
    chk("R2 early ack", cpu_ack, 1);
    chk("R2 no grant yet", sb_gnt, 0);
    cpu_req = 0;
    step();
    chk("R2 pulse", cpu_ack, 0);
    step();
    chk("R4 wait grant", sb_cyc, 0);
    sb_gnt = 1;
    step();
    step();
    chk("R4 posted cyc", sb_cyc, 1);
    chk("R4 posted addr", sb_addr, 32'h2000_0010);
    chk("R4 posted data", sb_wdata, 32'h1234_5678);
    sb_dack = 1;
    step();
    sb_dack = 0;
    chk("R4 cyc ends", sb_cyc, 0);
    chk("R2 no second ack", cpu_ack, 0);
    step();
    chk("R6 release posted", sb_req, 0);
    sb_gnt = 0;
  endtask

  task automatic t_posted_slv();
    cfg_wr(2'd0, 2'b11);
    cpu_req = 1; cpu_addr = 32'h3000_0000; cpu_wdata = 32'h0000_00AA;
    step();
    chk("R3 no ack before own", cpu_ack, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 wait grant", cpu_ack, 0);
    end
    sb_gnt = 1;
    step();
    chk("R3 first owned cycle", cpu_ack, 0);
    step();
    chk("R3 ack after own", cpu_ack, 1);
    cpu_req = 0;
    step();
    chk("R4 cyc slv", sb_cyc, 1);
    chk("R4 addr slv", sb_addr, 32'h3000_0000);
    sb_dack = 1;
    step();
    sb_dack = 0;
    step();
    chk("R6 release slv", sb_req, 0);
    sb_gnt = 0;
  endtask

  task automatic t_one_entry();
    cfg_wr(2'd0, 2'b01);
    sb_gnt = 1;
    cpu_req = 1; cpu_addr = 32'h4000_0004; cpu_wdata = 32'h0000_1111;
    step();
    chk("R2 first ack", cpu_ack, 1);
    cpu_addr = 32'h4000_0008; cpu_wdata = 32'h0000_2222;
    step();
    chk("R5 second held", cpu_ack, 0);
    step();
    chk("R4 first cyc", sb_cyc, 1);
    chk("R4 first addr", sb_addr, 32'h4000_0004);
    chk("R5 held during cyc", cpu_ack, 0);
    step();
    chk("R5 held while dack low", cpu_ack, 0);
    sb_dack = 1;
    step();
    sb_dack = 0;
    chk("R5 held at drain", cpu_ack, 0);
    chk("R6 kept", sb_req, 1);
    step();
    chk("R5 second ack", cpu_ack, 1);
    chk("R6 still owned", sb_req, 1);
    cpu_req = 0;
    step();
    chk("R4 second cyc", sb_cyc, 1);
    chk("R4 second addr", sb_addr, 32'h4000_0008);
    chk("R4 second data", sb_wdata, 32'h0000_2222);
    sb_dack = 1;
    step();
    sb_dack = 0;
    chk("R6 owned after last", sb_req, 1);
    step();
    chk("R6 release after last", sb_req, 0);
    sb_gnt = 0;
  endtask

  task automatic t_post_err();
    logic [1:0] v;
    cfg_wr(2'd0, 2'b01);
    cfg_wr(2'd1, 2'b00);
    sb_gnt = 1;
    cpu_req = 1; cpu_addr = 32'h5000_0000; cpu_wdata = 32'hDEAD_BEEF;
    step();
    chk("R2 ack before error", cpu_ack, 1);
    cpu_req = 0;
    step();
    step();
    chk("R4 err cyc", sb_cyc, 1);
    sb_berr = 1;
    step();
    sb_berr = 0;
    chk("R8 no berr", cpu_berr, 0);
    chk("R9 masked", irq, 0);
    cfg_rd(2'd2, v);
    chk("R8 flag set", v, 1);
    step();
    chk("R8 no berr later", cpu_berr, 0);
    sb_gnt = 0;
    cfg_wr(2'd1, 2'b01);
    chk("R9 irq on enable", irq, 1);
    cfg_wr(2'd2, 2'b00);
    chk("R9 write 0 keeps", irq, 1);
    cfg_wr(2'd1, 2'b00);
    chk("R9 mask off", irq, 0);
    cfg_wr(2'd1, 2'b01);
    cfg_wr(2'd2, 2'b01);
    chk("R9 w1c irq", irq, 0);
    cfg_rd(2'd2, v);
    chk("R9 w1c flag", v, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    cpu_req = 0; cpu_addr = 0; cpu_wdata = 0;
    sb_gnt = 0; sb_dack = 0; sb_berr = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    t_reset();
    t_unposted(1'b0);
    t_unposted(1'b1);
    t_posted_early();
    t_posted_slv();
    t_one_entry();
    t_post_err();
    repeat (2) step();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule